// File: doc/BRIEF.md
# Three-Colour Token Policer

This block meters a stream of packets against a committed rate with two burst allowances and gives each packet one of three colours: conform, exceed or violate. A committed token bucket refills from a periodic time-base strobe at a quantised rate and is capped at the committed burst. Whatever would overflow it spills into an excess bucket that is capped at the excess burst. Each colour has its own configured action: pass, drop, or pass with a replacement DSCP value. The block reports the colour, a drop flag, a remark flag and the DSCP to write.

Tokens are counted in bits. A packet costs eight tokens per charged byte. The charged byte count is the full layer-2 frame length on `pkt_len`, which covers both MAC addresses, the EtherType, any VLAN tags, the payload and the CRC, plus a signed per-policy adjustment. Each `tick` stands for one millisecond, so a rate in kbps adds exactly that many bit-tokens per tick.

A small control machine orders the work. ST_LOAD is held during reset and occupies the first cycle after it; in that cycle both buckets are filled. ST_IDLE means no packet is waiting. ST_MARK means a captured packet is being coloured and its bucket is being debited. The transitions are:
- ST_LOAD goes to ST_MARK on `pkt_valid`, and to ST_IDLE otherwise.
- ST_IDLE goes to ST_MARK on `pkt_valid`, and stays in ST_IDLE otherwise.
- ST_MARK stays in ST_MARK on `pkt_valid`, so packets can arrive back to back, and returns to ST_IDLE otherwise.

Top module: `tricolor_policer`

## Requirements
- R1: The charged length is `pkt_len + pkt_adj`. `pkt_adj` is a 7-bit two's complement value, and -64 is treated as -63, so the adjustment stays within ±63. A result below 1 is charged as 1. The packet costs charged×8 tokens.
- R2: The effective rate is `cfg_rate` (kbps) rounded down to a multiple of 8. If that is below 66, it is raised to 66. Each edge with `tick` high adds the effective rate, in bit-tokens, to the committed bucket.
- R3: The committed bucket never exceeds `cfg_cbs`×8. Refill that would exceed this cap spills into the excess bucket, which never exceeds the excess burst×8. Tokens beyond both caps are lost.
- R4: The excess burst is `cfg_ebs` bytes, or twice `cfg_cbs` when `cfg_ebs` is 0.
- R5: In the first cycle after reset is released, both buckets are filled to their caps.
- R6: A packet is conform (colour code 0) when the committed bucket holds at least its cost. Only the committed bucket is then debited.
- R7: A packet is exceed (colour code 1) when the committed bucket holds less than its cost but the excess bucket holds at least its cost. Only the excess bucket is then debited.
- R8: Otherwise the packet is violate (colour code 2), and neither bucket is debited.
- R9: Each colour has a 2-bit action code: 0 pass, 1 drop, 2 pass with remark, 3 pass. `res_drop` is 1 only for code 1. `res_remark` is 1 only for code 2, and `res_dscp` then carries that colour's configured DSCP. Otherwise `res_dscp` is 0.
- R10: A packet sampled at one clock edge produces a one-cycle `res_valid` after the next edge. A packet may be presented on every cycle. Colouring uses the bucket contents from before that edge, and a tick on the same edge is applied together with the debit.
- R11: While reset is asserted, and until the first result, `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Refill time-base strobe, one per millisecond |
| pkt_valid | input | 1 | Packet length strobe |
| pkt_len | input | LEN_W | Layer-2 frame length in bytes |
| pkt_adj | input | ADJ_W | Signed length adjustment in bytes |
| cfg_rate | input | RATE_W | Committed rate in kbps |
| cfg_cbs | input | BURST_W | Committed burst in bytes |
| cfg_ebs | input | BURST_W | Excess burst in bytes, 0 selects the default |
| cfg_act_conform | input | 2 | Action code for conform |
| cfg_act_exceed | input | 2 | Action code for exceed |
| cfg_act_violate | input | 2 | Action code for violate |
| cfg_dscp_conform | input | 6 | Replacement DSCP for conform |
| cfg_dscp_exceed | input | 6 | Replacement DSCP for exceed |
| cfg_dscp_violate | input | 6 | Replacement DSCP for violate |
| res_valid | output | 1 | Result strobe |
| res_color | output | 2 | Colour code |
| res_drop | output | 1 | Drop the packet |
| res_remark | output | 1 | Rewrite the DSCP |
| res_dscp | output | 6 | DSCP to write |

## Verification
The hardest condition to reach from the ports is a bucket that sits exactly at the edge of a packet's cost just after a spill: the committed bucket is partly drained, and the excess bucket is being refilled only by overflow from the committed one. The stimulus reaches this state deterministically. Known packet sizes empty both buckets, a counted number of ticks refills them past the committed cap, and packets one byte either side of the remaining tokens then probe each colour. A long sweep over several rate, burst and action settings follows. It mixes random lengths, adjustments, ticks that land on the colouring edge, and back-to-back packets, and an arithmetic bucket model in the bench predicts every result.

// File: rtl/tricolor_pkg.sv
package tricolor_pkg;

    typedef enum logic [1:0] {
        CLR_CONFORM = 2'd0,
        CLR_EXCEED  = 2'd1,
        CLR_VIOLATE = 2'd2
    } color_e;

    typedef enum logic [1:0] {
        ACT_PASS     = 2'd0,
        ACT_DROP     = 2'd1,
        ACT_REMARK   = 2'd2,
        ACT_PASS_ALT = 2'd3
    } act_e;

    typedef struct packed {
        logic       drop;
        logic       remark;
        logic [5:0] dscp;
    } verdict_t;

    function automatic verdict_t apply_action(input logic [1:0] act, input logic [5:0] dscp);
        verdict_t v;
        v = '0;
        unique case (act_e'(act))
            ACT_DROP:   v.drop = 1'b1;
            ACT_REMARK: begin
                v.remark = 1'b1;
                v.dscp   = dscp;
            end
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tricolor_rate_quant.sv
module tricolor_rate_quant #(
    parameter int RATE_W    = 24,
    parameter int GRAN_LOG2 = 3,
    parameter int MIN_RATE  = 66
) (
    input  logic [RATE_W-1:0] rate_in,
    output logic [RATE_W-1:0] rate_eff
);
    localparam logic [RATE_W-1:0] FLOOR = RATE_W'(MIN_RATE);

    logic [RATE_W-1:0] rounded;

    generate
        if (GRAN_LOG2 == 0) begin : g_no_round
            assign rounded = rate_in;
        end else begin : g_round
            assign rounded = {rate_in[RATE_W-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
        end
    endgenerate

    assign rate_eff = (rounded < FLOOR) ? FLOOR : rounded;
endmodule

// File: rtl/tricolor_len_charge.sv
module tricolor_len_charge #(
    parameter int LEN_W   = 14,
    parameter int ADJ_W   = 7,
    parameter int ADJ_LIM = 63
) (
    input  logic [LEN_W-1:0]        pkt_len,
    input  logic signed [ADJ_W-1:0] pkt_adj,
    output logic [LEN_W:0]          charged
);
    localparam int SW = LEN_W + 2;
    localparam logic signed [ADJ_W-1:0] ADJ_LO = ADJ_W'(-ADJ_LIM);
    localparam logic signed [ADJ_W-1:0] ADJ_HI = ADJ_W'(ADJ_LIM);

    logic signed [ADJ_W-1:0] adj_sat;
    logic signed [SW-1:0]    len_s;
    logic signed [SW-1:0]    adj_s;
    logic signed [SW-1:0]    sum;

    always_comb begin
        if (pkt_adj < ADJ_LO)      adj_sat = ADJ_LO;
        else if (pkt_adj > ADJ_HI) adj_sat = ADJ_HI;
        else                       adj_sat = pkt_adj;
        len_s = $signed({2'b00, pkt_len});
        adj_s = $signed({{(SW-ADJ_W){adj_sat[ADJ_W-1]}}, adj_sat});
        sum   = len_s + adj_s;
        if (sum < $signed(SW'(1))) charged = (LEN_W+1)'(1);
        else                       charged = sum[LEN_W:0];
    end
endmodule

// File: rtl/tricolor_token_pair.sv
module tricolor_token_pair
    import tricolor_pkg::*;
#(
    parameter int TOK_W  = 24,
    parameter int RATE_W = 24,
    parameter int NEED_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic              dec_en,
    input  logic [NEED_W-1:0] need,
    input  logic [RATE_W-1:0] add,
    input  logic [TOK_W-1:0]  cap_c,
    input  logic [TOK_W-1:0]  cap_e,
    output color_e            color
);
    localparam int MX1   = (TOK_W > RATE_W) ? TOK_W : RATE_W;
    localparam int MX2   = (MX1 > NEED_W) ? MX1 : NEED_W;
    localparam int SUM_W = MX2 + 2;

    logic [TOK_W-1:0] tc_q, te_q;
    logic [SUM_W-1:0] tc_w, te_w, need_w, capc_w, cape_w;
    logic [SUM_W-1:0] deb_c, deb_e, refill, c_after, spill, e_after;
    logic [TOK_W-1:0] tc_d, te_d;

    always_comb begin
        tc_w   = SUM_W'(tc_q);
        te_w   = SUM_W'(te_q);
        need_w = SUM_W'(need);
        capc_w = SUM_W'(cap_c);
        cape_w = SUM_W'(cap_e);

        if (tc_w >= need_w)      color = CLR_CONFORM;
        else if (te_w >= need_w) color = CLR_EXCEED;
        else                     color = CLR_VIOLATE;

        deb_c  = (dec_en && color == CLR_CONFORM) ? need_w : '0;
        deb_e  = (dec_en && color == CLR_EXCEED)  ? need_w : '0;
        refill = tick ? SUM_W'(add) : '0;

        c_after = tc_w - deb_c + refill;
        if (c_after > capc_w) begin
            spill = c_after - capc_w;
            tc_d  = cap_c;
        end else begin
            spill = '0;
            tc_d  = c_after[TOK_W-1:0];
        end

        e_after = te_w - deb_e + spill;
        te_d    = (e_after > cape_w) ? cap_e : e_after[TOK_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q <= '0;
            te_q <= '0;
        end else if (load) begin
            tc_q <= cap_c;
            te_q <= cap_e;
        end else begin
            tc_q <= tc_d;
            te_q <= te_d;
        end
    end

    p_commit_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tc_q <= $past(cap_c));
    p_excess_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> te_q <= $past(cap_e));
    p_full_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tc_q == $past(cap_c)) && (te_q == $past(cap_e)));
    p_conform_spares_excess_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !load && color == CLR_CONFORM) |=> (te_q >= $past(te_q)) || (te_q == $past(cap_e)));
    p_exceed_spares_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !load && color == CLR_EXCEED) |=> (tc_q >= $past(tc_q)) || (tc_q == $past(cap_c)));
    p_violate_no_debit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !load && color == CLR_VIOLATE) |=>
            ((tc_q >= $past(tc_q)) || (tc_q == $past(cap_c))) &&
            ((te_q >= $past(te_q)) || (te_q == $past(cap_e))));
endmodule

// File: rtl/tricolor_policer.sv
module tricolor_policer
    import tricolor_pkg::*;
#(
    parameter int LEN_W     = 14,
    parameter int ADJ_W     = 7,
    parameter int ADJ_LIM   = 63,
    parameter int RATE_W    = 24,
    parameter int BURST_W   = 20,
    parameter int GRAN_LOG2 = 3,
    parameter int MIN_RATE  = 66
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     pkt_valid,
    input  logic [LEN_W-1:0]         pkt_len,
    input  logic signed [ADJ_W-1:0]  pkt_adj,
    input  logic [RATE_W-1:0]        cfg_rate,
    input  logic [BURST_W-1:0]       cfg_cbs,
    input  logic [BURST_W-1:0]       cfg_ebs,
    input  logic [1:0]               cfg_act_conform,
    input  logic [1:0]               cfg_act_exceed,
    input  logic [1:0]               cfg_act_violate,
    input  logic [5:0]               cfg_dscp_conform,
    input  logic [5:0]               cfg_dscp_exceed,
    input  logic [5:0]               cfg_dscp_violate,
    output logic                     res_valid,
    output logic [1:0]               res_color,
    output logic                     res_drop,
    output logic                     res_remark,
    output logic [5:0]               res_dscp
);
    localparam int TOK_W  = BURST_W + 4;
    localparam int CHG_W  = LEN_W + 1;
    localparam int NEED_W = CHG_W + 3;
    localparam int STEP   = 1 << GRAN_LOG2;

    typedef enum logic [1:0] {ST_LOAD, ST_IDLE, ST_MARK} st_e;

    st_e                state_q, state_d;
    logic [CHG_W-1:0]   charged, len_q;
    logic [RATE_W-1:0]  rate_eff;
    logic [BURST_W:0]   ebs_eff;
    logic [TOK_W-1:0]   cap_c, cap_e;
    color_e             mark_color;
    logic [1:0]         sel_act;
    logic [5:0]         sel_dscp;
    verdict_t           verdict;

    tricolor_rate_quant #(.RATE_W(RATE_W), .GRAN_LOG2(GRAN_LOG2), .MIN_RATE(MIN_RATE)) u_quant (
        .rate_in (cfg_rate),
        .rate_eff(rate_eff)
    );

    tricolor_len_charge #(.LEN_W(LEN_W), .ADJ_W(ADJ_W), .ADJ_LIM(ADJ_LIM)) u_len (
        .pkt_len(pkt_len),
        .pkt_adj(pkt_adj),
        .charged(charged)
    );

    assign ebs_eff = (cfg_ebs == '0) ? {cfg_cbs, 1'b0} : {1'b0, cfg_ebs};
    assign cap_c   = TOK_W'({cfg_cbs, 3'b000});
    assign cap_e   = TOK_W'({ebs_eff, 3'b000});

    tricolor_token_pair #(.TOK_W(TOK_W), .RATE_W(RATE_W), .NEED_W(NEED_W)) u_tokens (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == ST_LOAD),
        .tick  (tick),
        .dec_en(state_q == ST_MARK),
        .need  ({len_q, 3'b000}),
        .add   (rate_eff),
        .cap_c (cap_c),
        .cap_e (cap_e),
        .color (mark_color)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = pkt_valid ? ST_MARK : ST_IDLE;
            ST_IDLE: state_d = pkt_valid ? ST_MARK : ST_IDLE;
            ST_MARK: state_d = pkt_valid ? ST_MARK : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         len_q <= '0;
        else if (pkt_valid) len_q <= charged;
    end

    always_comb begin
        unique case (mark_color)
            CLR_CONFORM: begin sel_act = cfg_act_conform; sel_dscp = cfg_dscp_conform; end
            CLR_EXCEED:  begin sel_act = cfg_act_exceed;  sel_dscp = cfg_dscp_exceed;  end
            default:     begin sel_act = cfg_act_violate; sel_dscp = cfg_dscp_violate; end
        endcase
        verdict = apply_action(sel_act, sel_dscp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_color  <= 2'd0;
            res_drop   <= 1'b0;
            res_remark <= 1'b0;
            res_dscp   <= 6'd0;
        end else begin
            res_valid <= (state_q == ST_MARK);
            if (state_q == ST_MARK) begin
                res_color  <= mark_color;
                res_drop   <= verdict.drop;
                res_remark <= verdict.remark;
                res_dscp   <= verdict.dscp;
            end
        end
    end

    p_charge_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> len_q >= CHG_W'(1));
    p_rate_on_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rate_eff % RATE_W'(STEP)) == '0) || (rate_eff == RATE_W'(MIN_RATE)));
    p_rate_not_raised_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_eff <= cfg_rate) || (rate_eff == RATE_W'(MIN_RATE)));
    p_drop_or_remark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(res_drop && res_remark));
    p_dscp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_remark |-> res_dscp == 6'd0);
    p_result_after_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(state_q) == ST_MARK);
    p_packet_yields_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> ##1 res_valid);
endmodule

// File: tb/tricolor_policer_bench.sv
module tricolor_policer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [13:0] pkt_len = '0;
    logic signed [6:0] pkt_adj = '0;
    logic [23:0] cfg_rate = 24'd70;
    logic [19:0] cfg_cbs = 20'd100;
    logic [19:0] cfg_ebs = 20'd0;
    logic [1:0]  act_c = 2'd0, act_e = 2'd2, act_v = 2'd1;
    logic [5:0]  dscp_c = 6'd10, dscp_e = 6'd12, dscp_v = 6'd14;
    logic        res_valid, res_drop, res_remark;
    logic [1:0]  res_color;
    logic [5:0]  res_dscp;

    int checks = 0;
    int failures = 0;

    longint m_tc, m_te, m_capc, m_cape, m_rate, m_plen;
    bit     m_load, m_pend;
    bit     e_valid;
    int     e_color;
    bit     e_drop, e_remark;
    int     e_dscp;
    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;

    tricolor_policer u_tricolor_policer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pkt_valid(pkt_valid),
        .pkt_len(pkt_len), .pkt_adj(pkt_adj), .cfg_rate(cfg_rate),
        .cfg_cbs(cfg_cbs), .cfg_ebs(cfg_ebs),
        .cfg_act_conform(act_c), .cfg_act_exceed(act_e), .cfg_act_violate(act_v),
        .cfg_dscp_conform(dscp_c), .cfg_dscp_exceed(dscp_e), .cfg_dscp_violate(dscp_v),
        .res_valid(res_valid), .res_color(res_color), .res_drop(res_drop),
        .res_remark(res_remark), .res_dscp(res_dscp)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic longint charge(input int len, input int adj);
        longint c;
        int a;
        a = (adj < -63) ? -63 : adj;
        c = len + a;
        return (c < 1) ? 1 : c;
    endfunction

    task automatic do_reset();
        longint q;
        longint ebs;
        rst_n = 1'b0;
        pkt_valid = 1'b0;
        tick = 1'b0;
        repeat (2) @(negedge clk);
        chk(res_valid == 1'b0, "R11 res_valid in reset", res_valid, 0);
        q = (longint'(cfg_rate) / 8) * 8;
        m_rate = (q < 66) ? 66 : q;
        m_capc = longint'(cfg_cbs) * 8;
        ebs = (cfg_ebs == 0) ? 2 * longint'(cfg_cbs) : longint'(cfg_ebs);
        m_cape = ebs * 8;
        m_tc = 0;
        m_te = 0;
        m_load = 1'b1;
        m_pend = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic model_edge(input bit v, input int len, input int adj, input bit tk);
        longint need, dc, de, ca, sp, ea;
        int a;
        e_valid = 1'b0;
        if (m_load) begin
            m_tc = m_capc;
            m_te = m_cape;
            m_load = 1'b0;
        end else begin
            dc = 0;
            de = 0;
            if (m_pend) begin
                need = m_plen * 8;
                e_valid = 1'b1;
                if (m_tc >= need)      begin e_color = 0; dc = need; end
                else if (m_te >= need) begin e_color = 1; de = need; end
                else                   e_color = 2;
                a = (e_color == 0) ? act_c : (e_color == 1) ? act_e : act_v;
                e_drop = (a == 1);
                e_remark = (a == 2);
                e_dscp = !e_remark ? 0 : (e_color == 0) ? dscp_c : (e_color == 1) ? dscp_e : dscp_v;
            end
            ca = m_tc - dc + (tk ? m_rate : 0);
            if (ca > m_capc) begin sp = ca - m_capc; m_tc = m_capc; end
            else             begin sp = 0; m_tc = ca; end
            ea = m_te - de + sp;
            m_te = (ea > m_cape) ? m_cape : ea;
        end
        m_pend = v;
        m_plen = charge(len, adj);
    endtask

    task automatic step(input bit v, input int len, input int adj, input bit tk);
        pkt_valid = v;
        pkt_len = 14'(len);
        pkt_adj = 7'(adj);
        tick = tk;
        @(posedge clk);
        model_edge(v, len, adj, tk);
        @(negedge clk);
        pkt_valid = 1'b0;
        tick = 1'b0;
        chk(res_valid == e_valid, "R10 result strobe timing", res_valid, e_valid);
        if (e_valid && res_valid) begin
            chk(res_color == 2'(e_color),
                (e_color == 0) ? "R6 colour" : (e_color == 1) ? "R7 colour" : "R8 colour",
                res_color, e_color);
            chk(res_drop == e_drop && res_remark == e_remark && res_dscp == 6'(e_dscp),
                "R9 action", {res_drop, res_remark, res_dscp}, {e_drop, e_remark, 6'(e_dscp)});
        end
    endtask

    task automatic pkt(input int len, input int adj, input bit tk, input int exp_color, input string tag);
        step(1'b1, len, adj, 1'b0);
        step(1'b0, 0, 0, tk);
        chk(res_valid && res_color == 2'(exp_color), tag, res_color, exp_color);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        cfg_rate = 24'd70; cfg_cbs = 20'd100; cfg_ebs = 20'd0;
        do_reset();
        step(1'b0, 0, 0, 1'b0);
        chk(res_valid == 1'b0, "R11 idle after reset", res_valid, 0);
        pkt(100, 0, 1'b0, 0, "R5 full committed conforms");
        pkt(200, 0, 1'b0, 1, "R4 default excess holds 2x cbs");
        pkt(1, 0, 1'b0, 2, "R8 both empty violate");
        ticks(15);
        pkt(100, 0, 1'b0, 0, "R3 committed capped at cbs");
        pkt(23, 0, 1'b0, 1, "R3 spill reached excess");
        pkt(1, 0, 1'b0, 2, "R3 spill capped");
        do_reset();
        step(1'b0, 0, 0, 1'b0);
        pkt(164, -64, 1'b0, 1, "R1 adj -64 acts as -63");
        pkt(100, 0, 1'b0, 0, "R6 exceed left committed intact");
        pkt(10, -63, 1'b0, 1, "R1 charge clamped to 1");
        cfg_rate = 24'd5;
        do_reset();
        step(1'b0, 0, 0, 1'b0);
        pkt(100, 0, 1'b0, 0, "R2 drain");
        ticks(1);
        pkt(8, 0, 1'b0, 0, "R2 floor 66 refill");
        cfg_rate = 24'd1007; cfg_cbs = 20'd300; cfg_ebs = 20'd5;
        do_reset();
        step(1'b0, 0, 0, 1'b0);
        pkt(150, 0, 1'b0, 0, "R6 drain a");
        pkt(150, 0, 1'b0, 0, "R6 drain b");
        ticks(2);
        pkt(251, 0, 1'b0, 2, "R2 rate rounded down");
        step(1'b1, 125, 0, 1'b0);
        step(1'b1, 125, 0, 1'b1);
        step(1'b1, 1, 0, 1'b0);
        step(1'b0, 0, 0, 1'b0);
        chk(res_valid && res_color == 2'd0, "R10 tick applied with debit", res_color, 0);

        for (int c = 0; c < 6; c++) begin
            int rates[6] = '{5, 71, 300, 1007, 4000, 66};
            int cbss[6]  = '{100, 37, 250, 64, 500, 1};
            int ebss[6]  = '{0, 50, 0, 400, 0, 3};
            cfg_rate = 24'(rates[c]);
            cfg_cbs  = 20'(cbss[c]);
            cfg_ebs  = 20'(ebss[c]);
            act_c = 2'(c); act_e = 2'(c + 1); act_v = 2'(c + 2);
            dscp_c = 6'(c * 7 + 1); dscp_e = 6'(c * 5 + 20); dscp_v = 6'(c * 3 + 40);
            do_reset();
            for (int i = 0; i < 300; i++) begin
                int len, adj;
                len = int'(rnd() % (cbss[c] * 3 + 80));
                adj = int'(rnd() % 128) - 64;
                step((rnd() % 4) != 0, len, adj, (rnd() % 4) == 0);
            end
            step(1'b0, 0, 0, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule